// File: doc/BRIEF.md
# SDRAM Control Register Bank with Self-Refresh Entry Timer

This block is the software-visible control register bank for a small SDRAM controller. A byte-wide register port sets which chip-enable pins carry SDRAM chip selects, turns the shared SDRAM pins and the SDRAM clock on or off, and starts the power-up initialization sequence. A separate sequencer, outside this block, runs that sequence and reports when it is done. The block also holds a self-refresh enable bit and a programmable idle limit.

While self-refresh is armed, a small timer watches the access and auto-refresh strobes. When no strobe has arrived for the programmed number of cycles, the timer drives the SDRAM clock-enable (CKE) low. Any new activity raises CKE again on the next edge and restarts the count.

There are two synchronous, active-low resets. A cold reset clears every setting. A hot reset keeps the settings but cancels any initialization request and restarts the timer. The SDRAM clock enable output is gated off while either low-power flag is high.

Top module: `sdram_ctl_regs`

## Requirements
- R1: While coldRstN is low at a clock edge, every register is cleared. After that edge, every readable offset returns 0x00, ceSel is 0, pinShareEn, sdClkEn and initStart are 0, and cke is 1.
- R2: A write to offset 0 sets ceSel[0] from data bit 2 and ceSel[1] from data bit 3, one edge later. Each pin's bit is independent of the other and of any address area. Offset 0 reads back those two bits in the same positions, and every other bit of offset 0 reads as 0 whatever was written.
- R3: Offset 1 bit 7 is the interface enable and drives pinShareEn. sdClkEn is high only when the enable is set and both low-power flags are low.
- R4: While haltLp or sleepLp is high, sdClkEn is low in that same cycle, whatever the register contents.
- R5: A write of 1 to offset 1 bit 6 makes initStart high for exactly the one cycle after the write edge. A write of 0 to that bit gives no pulse and leaves the pending state unchanged.
- R6: Offset 1 bit 6 reads 1 from the edge after an init request until the edge on which initDone is seen high. It reads 0 after a cold or a hot reset.
- R7: Offset 1 bit 5 is the self-refresh enable. An accessReq or autoRefresh strobe seen at an edge makes cke 1 after that edge and restarts the idle count.
- R8: When the enable bit and the self-refresh bit are both set, and offset 2 bits [3:0] hold N, cke falls after the (N+1)th edge that follows the edge which saw the last activity strobe. With N = 0, cke falls one edge after the last activity.
- R9: While hotRstN is low at an edge, the routing bits, the enable, the self-refresh enable and the idle limit keep their values, and register writes in that cycle are ignored. The same edge clears the init request, drives initStart low, sets cke to 1 and restarts the idle count.
- R10: While either the enable bit or the self-refresh bit is clear, cke is 1 after each edge and the idle count holds at zero. Re-arming therefore starts a fresh count of N+1 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| coldRstN | input | 1 | Synchronous cold reset, active low; clears all state |
| hotRstN | input | 1 | Synchronous hot reset, active low; keeps settings |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 2 | Register offset: 0 routing, 1 control, 2 idle limit |
| busWdata | input | 8 | Register write data |
| busRdata | output | 8 | Combinational read data for busAddr |
| initDone | input | 1 | Sequencer reports that initialization has finished |
| accessReq | input | 1 | SDRAM access activity strobe |
| autoRefresh | input | 1 | Auto-refresh activity strobe |
| haltLp | input | 1 | Deep halt low-power flag |
| sleepLp | input | 1 | Sleep low-power flag |
| ceSel | output | 2 | Per-pin select: 1 = SDRAM chip select, 0 = general chip enable |
| pinShareEn | output | 1 | Shared pins switched to SDRAM use |
| sdClkEn | output | 1 | SDRAM clock output enable |
| initStart | output | 1 | One-cycle init sequence start pulse |
| cke | output | 1 | SDRAM clock enable; low means self-refresh |

## Verification
A counter that fails to restart, starts from a stale value, or advances while disarmed makes cke fall on the wrong edge. The bench sees this within N+1 cycles of the last strobe, because it samples cke on every cycle of each idle gap. A pending flag that sticks or clears too early shows up on the next read of offset 1. A hot reset that loses a setting shows up at once on ceSel or pinShareEn, or on the next read back of the idle limit.

// File: rtl/sdram_ctl_pkg.sv
package sdram_ctl_pkg;
  localparam int ADDR_W = 2;

  // register offsets
  localparam logic [ADDR_W-1:0] OFS_ROUTE = 2'd0;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 2'd1;
  localparam logic [ADDR_W-1:0] OFS_IDLE  = 2'd2;

  // field positions
  localparam int CE_PINS   = 2;
  localparam int CE_LSB    = 2;
  localparam int BIT_EN    = 7;
  localparam int BIT_INIT  = 6;
  localparam int BIT_SREN  = 5;

  // control -> datapath strobes
  typedef struct packed {
    logic wrRoute;
    logic wrCtrl;
    logic wrIdle;
    logic timerClr;
  } ctlStrobes_t;
endpackage

// File: rtl/sdram_ctl_decode.sv
module sdram_ctl_decode
  import sdram_ctl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              coldRstN,
  input  logic              hotRstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              initDone,
  output ctlStrobes_t       stb,
  output logic              initPend,
  output logic              initStart
);
  logic anyRst;
  logic wrOk;
  logic initKick;
  logic unusedData;

  assign anyRst     = !coldRstN || !hotRstN;
  assign wrOk       = busWr && !anyRst;
  assign initKick   = wrOk && (busAddr == OFS_CTRL) && busWdata[BIT_INIT];
  assign unusedData = ^busWdata;

  always_comb begin
    stb          = '0;
    stb.wrRoute  = wrOk && (busAddr == OFS_ROUTE);
    stb.wrCtrl   = wrOk && (busAddr == OFS_CTRL);
    stb.wrIdle   = wrOk && (busAddr == OFS_IDLE);
    stb.timerClr = anyRst;
  end

  always_ff @(posedge clk) begin
    if (anyRst) begin
      initStart <= 1'b0;
      initPend  <= 1'b0;
    end else begin
      initStart <= initKick;
      if (initKick)      initPend <= 1'b1;
      else if (initDone) initPend <= 1'b0;
    end
  end
endmodule

// File: rtl/sdram_ctl_datapath.sv
module sdram_ctl_datapath
  import sdram_ctl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDLE_W = 4
) (
  input  logic               clk,
  input  logic               coldRstN,
  input  ctlStrobes_t        stb,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [ADDR_W-1:0]  rdAddr,
  input  logic               initPend,
  input  logic               accessReq,
  input  logic               autoRefresh,
  output logic [CE_PINS-1:0] ceSel,
  output logic               enQ,
  output logic               srEnQ,
  output logic               cke,
  output logic [DATA_W-1:0]  rdata
);
  logic [IDLE_W-1:0] idleLimit;
  logic [IDLE_W-1:0] idleCnt;
  logic              armed;
  logic              activity;
  logic              unusedWdata;

  assign unusedWdata = ^wdata;
  assign armed       = enQ && srEnQ;
  assign activity    = accessReq || autoRefresh;

  // one routing flop per chip-enable pin
  for (genvar g = 0; g < CE_PINS; g++) begin : g_route
    always_ff @(posedge clk) begin
      if (!coldRstN)       ceSel[g] <= 1'b0;
      else if (stb.wrRoute) ceSel[g] <= wdata[CE_LSB + g];
    end
  end

  always_ff @(posedge clk) begin
    if (!coldRstN) begin
      enQ       <= 1'b0;
      srEnQ     <= 1'b0;
      idleLimit <= '0;
    end else begin
      if (stb.wrCtrl) begin
        enQ   <= wdata[BIT_EN];
        srEnQ <= wdata[BIT_SREN];
      end
      if (stb.wrIdle) idleLimit <= wdata[IDLE_W-1:0];
    end
  end

  // self-refresh entry timer
  always_ff @(posedge clk) begin
    if (!coldRstN || stb.timerClr || activity || !armed) begin
      idleCnt <= '0;
      cke     <= 1'b1;
    end else if (cke) begin
      if (idleCnt >= idleLimit) cke <= 1'b0;
      else                      idleCnt <= idleCnt + 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (rdAddr)
      OFS_ROUTE: rdata[CE_LSB +: CE_PINS] = ceSel;
      OFS_CTRL: begin
        rdata[BIT_EN]   = enQ;
        rdata[BIT_INIT] = initPend;
        rdata[BIT_SREN] = srEnQ;
      end
      OFS_IDLE: rdata[IDLE_W-1:0] = idleLimit;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/sdram_ctl_regs.sv
module sdram_ctl_regs
  import sdram_ctl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDLE_W = 4
) (
  input  logic              clk,
  input  logic              coldRstN,
  input  logic              hotRstN,
  input  logic              busWr,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              initDone,
  input  logic              accessReq,
  input  logic              autoRefresh,
  input  logic              haltLp,
  input  logic              sleepLp,
  output logic [1:0]        ceSel,
  output logic              pinShareEn,
  output logic              sdClkEn,
  output logic              initStart,
  output logic              cke
);
  ctlStrobes_t stb;
  logic        initPend;
  logic        srEnQ;

  sdram_ctl_decode #(.DATA_W(DATA_W)) u_decode (
    .clk(clk), .coldRstN(coldRstN), .hotRstN(hotRstN),
    .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .initDone(initDone), .stb(stb), .initPend(initPend),
    .initStart(initStart)
  );

  sdram_ctl_datapath #(.DATA_W(DATA_W), .IDLE_W(IDLE_W)) u_dp (
    .clk(clk), .coldRstN(coldRstN), .stb(stb), .wdata(busWdata),
    .rdAddr(busAddr), .initPend(initPend), .accessReq(accessReq),
    .autoRefresh(autoRefresh), .ceSel(ceSel), .enQ(pinShareEn),
    .srEnQ(srEnQ), .cke(cke), .rdata(busRdata)
  );

  assign sdClkEn = pinShareEn && !haltLp && !sleepLp;
endmodule

// File: rtl/sdram_ctl_regs_chk.sv
module sdram_ctl_regs_chk
  import sdram_ctl_pkg::*;
(
  input logic       clk,
  input logic       coldRstN,
  input logic       hotRstN,
  input logic       busWr,
  input logic [1:0] busAddr,
  input logic [7:0] busWdata,
  input logic       accessReq,
  input logic       autoRefresh,
  input logic       haltLp,
  input logic       sleepLp,
  input logic       initStart,
  input logic       sdClkEn,
  input logic       cke,
  input logic [1:0] ceSel,
  input logic       pinShareEn,
  input logic       srEnQ
);
  // R4
  lp_clk_stop_chk: assert property (@(posedge clk) disable iff (!coldRstN)
    (haltLp || sleepLp) |-> !sdClkEn);

  // R3
  clk_needs_en_chk: assert property (@(posedge clk) disable iff (!coldRstN)
    sdClkEn |-> pinShareEn);

  // R5
  init_pulse_src_chk: assert property (@(posedge clk) disable iff (!coldRstN)
    initStart |-> $past(busWr && hotRstN && busAddr == OFS_CTRL && busWdata[BIT_INIT]));

  // R7
  wake_chk: assert property (@(posedge clk) disable iff (!coldRstN)
    (accessReq || autoRefresh) |=> cke);

  // R10
  disarm_chk: assert property (@(posedge clk) disable iff (!coldRstN)
    !(srEnQ && pinShareEn) |=> cke);

  // R9
  hot_keep_chk: assert property (@(posedge clk) disable iff (!coldRstN)
    !hotRstN |=> ($stable(ceSel) && $stable(pinShareEn) && $stable(srEnQ)
                  && !initStart && cke));
endmodule

bind sdram_ctl_regs sdram_ctl_regs_chk u_chk (
  .clk(clk), .coldRstN(coldRstN), .hotRstN(hotRstN), .busWr(busWr),
  .busAddr(busAddr), .busWdata(busWdata), .accessReq(accessReq),
  .autoRefresh(autoRefresh), .haltLp(haltLp), .sleepLp(sleepLp),
  .initStart(initStart), .sdClkEn(sdClkEn), .cke(cke), .ceSel(ceSel),
  .pinShareEn(pinShareEn), .srEnQ(srEnQ)
);

// File: tb/sdram_ctl_regs_bench.sv
`timescale 1ns/1ps
module sdram_ctl_regs_bench;
  logic       clk = 1'b0;
  logic       coldRstN = 1'b0, hotRstN = 1'b1;
  logic       busWr = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [7:0] busWdata = 8'd0;
  logic [7:0] busRdata;
  logic       initDone = 1'b0, accessReq = 1'b0, autoRefresh = 1'b0;
  logic       haltLp = 1'b0, sleepLp = 1'b0;
  logic [1:0] ceSel;
  logic       pinShareEn, sdClkEn, initStart, cke;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  sdram_ctl_regs u_sdram_ctl_regs (
    .clk(clk), .coldRstN(coldRstN), .hotRstN(hotRstN), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .initDone(initDone), .accessReq(accessReq), .autoRefresh(autoRefresh),
    .haltLp(haltLp), .sleepLp(sleepLp), .ceSel(ceSel), .pinShareEn(pinShareEn),
    .sdClkEn(sdClkEn), .initStart(initStart), .cke(cke)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // write drives at a negedge, takes effect at the next posedge, returns at the negedge after it
  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    busAddr = a;
    #0.5;
    d = busRdata;
  endtask

  function automatic int expCke(input int k, input int n);
    return (k <= n) ? 1 : 0;
  endfunction

  // expected readback of routing offset from a written byte
  function automatic int expRoute(input logic [7:0] d);
    return {4'b0, d[3], d[2], 2'b0};
  endfunction

  initial begin
    #(5ns * 150000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    coldRstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      busRead(a[1:0], rd);
      check("R1 readback", rd, 0);
    end
    check("R1 ceSel", ceSel, 0);
    check("R1 pinShareEn", pinShareEn, 0);
    check("R1 sdClkEn", sdClkEn, 0);
    check("R1 initStart", initStart, 0);
    check("R1 cke", cke, 1);

    // R2 routing, random bytes
    for (int i = 0; i < 12; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      busWrite(2'd0, d);
      check("R2 ceSel", ceSel, {30'b0, d[3], d[2]});
      busRead(2'd0, rd);
      check("R2 readback", rd, expRoute(d));
    end
    busWrite(2'd0, 8'hF3);
    check("R2 ignored bits", ceSel, 0);
    busWrite(2'd0, 8'h04);
    check("R2 pin0 only", ceSel, 1);

    // R3 / R4
    busWrite(2'd1, 8'h80);
    check("R3 pinShareEn", pinShareEn, 1);
    check("R3 sdClkEn", sdClkEn, 1);
    haltLp = 1'b1; #0.5;
    check("R4 halt", sdClkEn, 0);
    haltLp = 1'b0; sleepLp = 1'b1; #0.5;
    check("R4 sleep", sdClkEn, 0);
    sleepLp = 1'b0; #0.5;
    check("R4 resume", sdClkEn, 1);

    // R5 / R6 init trigger
    busWrite(2'd1, 8'hC0);
    check("R5 pulse", initStart, 1);
    @(negedge clk);
    check("R5 pulse width", initStart, 0);
    busRead(2'd1, rd);
    check("R6 pending", rd, 8'hC0);
    busWrite(2'd1, 8'h80);
    check("R5 write0 no pulse", initStart, 0);
    busRead(2'd1, rd);
    check("R6 still pending", rd, 8'hC0);
    initDone = 1'b1;
    @(negedge clk);
    initDone = 1'b0;
    busRead(2'd1, rd);
    check("R6 acked", rd, 8'h80);

    // R10 disarmed: enable set, self-refresh clear
    busWrite(2'd2, 8'h03);
    repeat (30) @(negedge clk);
    check("R10 cke held", cke, 1);
    busWrite(2'd1, 8'h20);  // sr on, enable off
    repeat (30) @(negedge clk);
    check("R10 enable off", cke, 1);
    busWrite(2'd1, 8'hA0);  // arm: fresh count of N+1 edges
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      check("R10 fresh count", cke, expCke(k, 3));
    end

    // R7 wake from self-refresh
    autoRefresh = 1'b1;
    @(negedge clk);
    autoRefresh = 1'b0;
    check("R7 wake", cke, 1);

    // R8 directed N=0
    busWrite(2'd2, 8'h00);
    accessReq = 1'b1;
    @(negedge clk);
    accessReq = 1'b0;
    check("R8 N0 after strobe", cke, 1);
    @(negedge clk);
    check("R8 N0 drop", cke, 0);

    // R8 / R7 random idle limits and gaps
    for (int i = 0; i < 40; i++) begin
      int n, gap;
      n = $urandom_range(0, 15);
      gap = $urandom_range(1, 20);
      busWrite(2'd2, 8'(n));
      if ($urandom_range(0, 1) == 1) accessReq = 1'b1; else autoRefresh = 1'b1;
      @(negedge clk);
      accessReq = 1'b0; autoRefresh = 1'b0;
      check("R7 strobe", cke, 1);
      for (int k = 1; k <= gap; k++) begin
        @(negedge clk);
        check("R8 idle timing", cke, expCke(k, n));
      end
    end

    // R9 hot reset keeps settings
    busWrite(2'd0, 8'h0C);
    busWrite(2'd2, 8'h05);
    busWrite(2'd1, 8'hE0);
    hotRstN = 1'b0;
    busAddr = 2'd0; busWdata = 8'h00; busWr = 1'b1;
    @(negedge clk);
    hotRstN = 1'b1; busWr = 1'b0;
    check("R9 initStart low", initStart, 0);
    check("R9 cke high", cke, 1);
    check("R9 ceSel kept", ceSel, 3);
    busRead(2'd1, rd);
    check("R9 ctrl kept, init cleared", rd, 8'hA0);
    busRead(2'd2, rd);
    check("R9 idle kept", rd, 5);
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      check("R9 timer restart", cke, expCke(k, 5));
    end

    // R1 cold reset clears all
    coldRstN = 1'b0;
    @(negedge clk);
    coldRstN = 1'b1;
    for (int a = 0; a < 3; a++) begin
      busRead(a[1:0], rd);
      check("R1 cold clear", rd, 0);
    end
    check("R1 cold cke", cke, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule